// File: doc/BRIEF.md
# FFT Window Start Pulse Generator

This block sits between a sample-rate resampler and an FFT engine in an OFDM receiver. The resampler can skip or repeat samples, so the block follows the stream through a sample-valid strobe rather than through clock cycles. It counts valid samples modulo the symbol length. Its first valid sample after reset is position 0, and positions run from 0 to SYM_LEN-1, where SYM_LEN = FFT_LEN + CP_LEN. The defaults are FFT_LEN = 2048 and CP_LEN = 512, which give 2560 samples per symbol.

A timing estimator supplies the position of the symbol boundary in that counting frame, together with a one-cycle valid strobe. The block raises a one-cycle start pulse on the valid sample that lies CP_LEN positions after the estimated boundary. It then holds a window-active flag for the FFT_LEN useful samples that follow. The cyclic prefix is therefore never marked as active, and it is dropped without any explicit removal step.

A new estimate can arrive while a window is open. In that case it is held until the window has closed, so a window in progress is never cut short. Before any estimate has been received, no pulse is produced.

The control is a three-state machine:
- `ST_IDLE`: no estimate has been received yet.
- `ST_SEEK`: the block waits for the target sample.
- `ST_WIN`: a window is open.

The transitions are:
- `IDLE→SEEK`: the first estimate has been taken.
- `SEEK→WIN`: the target sample is seen.
- `WIN→SEEK`: the last window sample is consumed.

Top module: `fft_win_gen`

## Requirements
- R1: Before the first estimate strobe after reset, `win_start` and `win_act` stay low.
- R2: `win_start` is high for exactly one cycle, on the valid sample whose position equals (boundary estimate + CP_LEN) mod SYM_LEN. The position is the count of valid samples since reset, modulo SYM_LEN.
- R3: Without a new estimate, successive pulses are exactly SYM_LEN valid samples apart.
- R4: `win_act` is high for exactly FFT_LEN valid samples per window, starting with the pulse sample.
- R5: Only cycles with `smp_vld` high advance the position, so idle cycles between samples do not shift the pulse. `win_start` and `win_act` are low in any cycle without `smp_vld`.
- R6: An estimate that arrives while a window is open, including in the pulse cycle, does not shorten that window. It sets the position of the next window.
- R7: An estimate that arrives while no window is open takes effect for the very next window, and the old target is abandoned.
- R8: When estimate + CP_LEN reaches SYM_LEN or more, the target wraps to estimate + CP_LEN − SYM_LEN.
- R9: During and right after reset both outputs are low, and the position count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A resampled sample is present this cycle |
| est_vld | input | 1 | Boundary estimate strobe |
| est_pos | input | $clog2(FFT_LEN+CP_LEN) | Estimated symbol boundary position |
| win_start | output | 1 | One-cycle pulse on the first sample of an FFT window |
| win_act | output | 1 | Sample belongs to the current FFT window |

## Verification
The main function is driven in four ways, each of which shows a different fault:
- **Dense valid strobes after a single estimate** pin down the prefix offset and the symbol period.
- **Valid strobes with bubbles between them** show whether the design counts cycles instead of samples.
- **An estimate placed inside an open window** shows whether the target is switched early or the window is truncated.
- **An estimate placed in the gap before a window** shows whether it is wrongly deferred.

A boundary estimate near the end of the symbol exercises the target wrap.

// File: rtl/fft_win_pkg.sv
package fft_win_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEEK = 2'd1,
        ST_WIN  = 2'd2
    } win_state_e;
endpackage

// File: rtl/fft_win_pos_cnt.sv
module fft_win_pos_cnt #(
    parameter int SYM_LEN = 2560,
    parameter int CNT_W   = $clog2(SYM_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_LEN - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (adv)
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end
endmodule

// File: rtl/fft_win_target.sv
module fft_win_target #(
    parameter int SYM_LEN = 2560,
    parameter int CP_LEN  = 512,
    parameter int CNT_W   = $clog2(SYM_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             est_vld,
    input  logic [CNT_W-1:0] est_pos,
    input  logic             hold,
    input  logic             release_win,
    output logic [CNT_W-1:0] tgt,
    output logic             tgt_ok
);
    localparam logic [CNT_W:0] SYM_W = (CNT_W+1)'(SYM_LEN);
    localparam logic [CNT_W:0] CP_W  = (CNT_W+1)'(CP_LEN);

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] est_tgt;
    logic [CNT_W-1:0] pend;
    logic             pend_v;

    always_comb begin
        sum = {1'b0, est_pos} + CP_W;
        if (sum >= SYM_W)
            sum = sum - SYM_W;
        est_tgt = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt    <= '0;
            tgt_ok <= 1'b0;
            pend   <= '0;
            pend_v <= 1'b0;
        end else if (est_vld && (!hold || release_win)) begin
            tgt    <= est_tgt;
            tgt_ok <= 1'b1;
            pend_v <= 1'b0;
        end else if (est_vld) begin
            pend   <= est_tgt;
            pend_v <= 1'b1;
        end else if (release_win && pend_v) begin
            tgt    <= pend;
            pend_v <= 1'b0;
        end
    end
endmodule

// File: rtl/fft_win_len_cnt.sv
module fft_win_len_cnt #(
    parameter int FFT_LEN = 2048,
    parameter int LEN_W   = $clog2(FFT_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic last
);
    localparam logic [LEN_W-1:0] END_IDX = LEN_W'(FFT_LEN - 1);

    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= LEN_W'(1);
        else if (adv)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == END_IDX);
endmodule

// File: rtl/fft_win_gen.sv
module fft_win_gen
    import fft_win_pkg::*;
#(
    parameter int FFT_LEN = 2048,
    parameter int CP_LEN  = FFT_LEN / 4,
    parameter int SYM_LEN = FFT_LEN + CP_LEN,
    parameter int CNT_W   = $clog2(SYM_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic             est_vld,
    input  logic [CNT_W-1:0] est_pos,
    output logic             win_start,
    output logic             win_act
);
    win_state_e       state, state_nx;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] tgt;
    logic             tgt_ok;
    logic             hit;
    logic             len_last;
    logic             win_end;

    fft_win_pos_cnt #(.SYM_LEN(SYM_LEN), .CNT_W(CNT_W)) i_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (smp_vld),
        .pos   (pos)
    );

    fft_win_target #(.SYM_LEN(SYM_LEN), .CP_LEN(CP_LEN), .CNT_W(CNT_W)) i_tgt (
        .clk         (clk),
        .rst_n       (rst_n),
        .est_vld     (est_vld),
        .est_pos     (est_pos),
        .hold        ((state == ST_WIN) || hit),
        .release_win (win_end),
        .tgt         (tgt),
        .tgt_ok      (tgt_ok)
    );

    fft_win_len_cnt #(.FFT_LEN(FFT_LEN)) i_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hit),
        .adv   ((state == ST_WIN) && smp_vld),
        .last  (len_last)
    );

    assign hit     = (state == ST_SEEK) && smp_vld && (pos == tgt);
    assign win_end = (state == ST_WIN) && smp_vld && len_last;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (tgt_ok)  state_nx = ST_SEEK;
            ST_SEEK: if (hit)     state_nx = ST_WIN;
            ST_WIN:  if (win_end) state_nx = ST_SEEK;
            default:              state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        win_start = 1'b0;
        win_act   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SEEK: begin
                win_start = hit;
                win_act   = hit;
            end
            ST_WIN:  win_act = smp_vld;
            default: ;
        endcase
    end
endmodule

// File: rtl/fft_win_chk.sv
module fft_win_chk #(
    parameter int FFT_LEN = 2048,
    parameter int LEN_W   = $clog2(FFT_LEN) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic smp_vld,
    input logic est_vld,
    input logic win_start,
    input logic win_act
);
    logic             seen_est;
    logic [LEN_W-1:0] act_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_est <= 1'b0;
            act_cnt  <= '0;
        end else begin
            if (est_vld)
                seen_est <= 1'b1;
            if (win_start)
                act_cnt <= LEN_W'(1);
            else if (win_act)
                act_cnt <= act_cnt + 1'b1;
        end
    end

    AST_NO_PULSE_BEFORE_EST: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_est |-> !win_start); // R1
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> !win_start); // R2
    AST_PULSE_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |-> win_act); // R4
    AST_WIN_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (win_act && !win_start) |-> (act_cnt < LEN_W'(FFT_LEN))); // R4
    AST_START_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |-> smp_vld); // R5
    AST_ACT_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        win_act |-> smp_vld); // R5
endmodule

bind fft_win_gen fft_win_chk #(.FFT_LEN(FFT_LEN)) i_fft_win_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .est_vld   (est_vld),
    .win_start (win_start),
    .win_act   (win_act)
);

// File: tb/test_fft_win_gen.sv
module test_fft_win_gen;
    localparam int FFT = 16;
    localparam int CP  = 4;
    localparam int SYM = FFT + CP;
    localparam int CW  = $clog2(SYM);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic          est_vld = 1'b0;
    logic [CW-1:0] est_pos = '0;
    logic          win_start;
    logic          win_act;

    int checks = 0;
    int errors = 0;
    int sidx = 0;
    int n_pulse = 0, first_pulse = -1, last_pulse = -1;
    int act_run = 0, len_err = 0, viol = 0, act_miss = 0;

    always #4 clk = ~clk;

    fft_win_gen #(.FFT_LEN(FFT), .CP_LEN(CP)) i_fft_win_gen (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .est_vld(est_vld),
        .est_pos(est_pos), .win_start(win_start), .win_act(win_act)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (!smp_vld && (win_start || win_act)) viol++;
            if (win_start) begin
                if (!win_act) act_miss++;
                if (act_run != 0 && act_run != FFT) len_err++;
                act_run = 0;
                n_pulse++;
                if (first_pulse < 0) first_pulse = sidx;
                last_pulse = sidx;
            end
            if (win_act) act_run++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_stats();
        n_pulse = 0; first_pulse = -1; last_pulse = -1;
    endtask

    task automatic drive(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1 smp_vld = 1'b0;
            end
            @(posedge clk); #1 smp_vld = 1'b1;
            if (i > 0 || gap > 0) ; // index advances below
            @(negedge clk);
            #1 sidx++;
        end
        @(posedge clk); #1 smp_vld = 1'b0;
    endtask

    task automatic send_est(input int v);
        @(posedge clk); #1 smp_vld = 1'b0; est_vld = 1'b1; est_pos = CW'(v);
        @(posedge clk); #1 est_vld = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 start low in reset", int'(win_start), 0);
        check("R9 act low in reset", int'(win_act), 0);
        @(posedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic t_no_est();
        clr_stats();
        drive(30, 0);
        check("R1 no pulse before estimate", n_pulse, 0);
    endtask

    task automatic t_dense();
        clr_stats();
        send_est(3);
        drive(60, 0);
        check("R2 first pulse at est+CP", first_pulse, 47);
        check("R3 pulse count one per symbol", n_pulse, 3);
        check("R3 last pulse spacing", last_pulse, 87);
        drive(13, 0);
    endtask

    task automatic t_gaps();
        clr_stats();
        drive(40, 2);
        check("R5 pulses with bubbles", n_pulse, 2);
        check("R5 pulse position with bubbles", first_pulse, 107);
        check("R5 no output without valid", viol, 0);
    endtask

    task automatic t_mid_window();
        clr_stats();
        drive(5, 0);
        check("R3 pulse before mid-window est", first_pulse, 147);
        clr_stats();
        send_est(10);
        drive(40, 0);
        check("R6 new target used after window", first_pulse, 174);
        check("R6 single pulse", n_pulse, 1);
        check("R4 window length unchanged", len_err, 0);
    endtask

    task automatic t_wrap();
        drive(2, 0);
        clr_stats();
        send_est(18);
        drive(40, 0);
        check("R8 wrapped target", first_pulse, 202);
        check("R8 pulse count", n_pulse, 2);
    endtask

    task automatic t_seek_est();
        drive(8, 0);
        clr_stats();
        send_est(0);
        drive(25, 0);
        check("R7 estimate outside window applies now", first_pulse, 244);
        check("R7 old target abandoned", n_pulse, 1);
        drive(20, 0);
        check("R4 every window FFT_LEN long", len_err, 0);
        check("R4 act on pulse sample", act_miss, 0);
        check("R2 R5 no output without valid", viol, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_no_est();
        t_dense();
        t_gaps();
        t_mid_window();
        t_wrap();
        t_seek_est();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule